// File: doc/BRIEF.md
# SATA Completion FIS and Interrupt Generator

This block builds the two completion frames that a SATA host port places in its receive area when the device reports back: the device-to-host register frame and the set-device-bits frame. A request supplies the frame kind, the device status and error bytes, a per-event interrupt flag, an abort indication for failed commands and, for set-device-bits frames, the mask of finished queue tags. The block writes the frame into the receive area one byte per cycle through a byte-addressed write port. One cycle after the last byte, it pulses the matching port interrupt-status set lines.

The interrupt flag is carried per event. A completing command sends a register frame with the flag set. The acknowledgement for a newly queued command sends one with the flag clear, and so raises no register-frame interrupt. An ERR status always raises the task-file error interrupt, whatever the flag. The task-file data value that software reads follows the status and error of every register frame written.

Top module: `sata_fis_irq_gen`

## Requirements
- R1: A register frame (reqKind=0) is written as 20 bytes at addresses D2H_BASE+0..19, one byte per cycle, starting the cycle after the request is accepted. The bytes are: byte 0 = 8'h34, byte 1 = reqIntr at bit 6 and all other bits 0, byte 2 = status, byte 3 = error, bytes 4..19 = 8'h00.
- R2: A set-device-bits frame (reqKind=1) is written as 8 bytes at SDB_BASE+0..7. The bytes are: byte 0 = 8'hA1, byte 1 = reqIntr at bit 6 and all other bits 0, byte 2 = status, byte 3 = error, bytes 4..7 = reqFinished with the least significant byte first.
- R3: For a register frame, setDhrs pulses for exactly one cycle if and only if reqIntr was set. The pulse comes in the cycle that directly follows the last written byte.
- R4: For a register frame whose status has ERR (bit 0) set, setTfes pulses in that same cycle, whether or not reqIntr is set.
- R5: For a set-device-bits frame with ERR (bit 0) set in status, setTfes pulses and setSdbs stays low. Without ERR, setSdbs pulses only when reqIntr is set, and setTfes stays low.
- R6: With reqAbort set, the status byte is forced to 8'h41 (READY bit 6 plus ERR bit 0) and the error byte to 8'h04 (abort). This happens before the frame is assembled, whatever reqStatus and reqError hold.
- R7: tfdValue is {error, status} of the most recent register frame and is updated in the cycle after the interrupt cycle. Set-device-bits frames leave it unchanged. It resets to TFD_RESET (16'h007F).
- R8: reqReady is low from acceptance until the frame has finished. A request presented while reqReady is low is ignored: it writes no bytes, pulses nothing and leaves tfdValue unchanged.
- R9: After reset there are no writes and no interrupt pulses, and reqReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Frame request |
| reqKind | input | 1 | 0 = register frame, 1 = set-device-bits frame |
| reqIntr | input | 1 | Interrupt flag for this event |
| reqAbort | input | 1 | Failed command: force abort status and error |
| reqStatus | input | 8 | Device status byte |
| reqError | input | 8 | Device error byte |
| reqFinished | input | 32 | Finished-tag mask (set-device-bits only) |
| reqReady | output | 1 | Idle, request accepted when high |
| wrEn | output | 1 | Receive-area byte write strobe |
| wrAddr | output | 8 | Receive-area byte address |
| wrData | output | 8 | Receive-area byte data |
| setDhrs | output | 1 | Register-frame interrupt set pulse |
| setSdbs | output | 1 | Set-device-bits interrupt set pulse |
| setTfes | output | 1 | Task-file error interrupt set pulse |
| tfdValue | output | 16 | Task-file data {error, status} |

## Verification
Some rules are checked on every cycle: interrupt pulses only in the cycle right after a write burst, the register-frame pulse only with its flag, set-device-bits and task-file error never pulsing together, tfdValue moving only on a register-frame interrupt cycle, and an abort capturing the forced status. Other behaviour can only be shown by the bench's scenarios. This covers the exact byte content and addresses of each frame, the flag and ERR combinations for both frame kinds, the forced abort values reaching the receive area, and a request arriving mid-frame being dropped.

// File: rtl/sata_fis_pkg.sv
package sata_fis_pkg;
  localparam int IDX_W   = 5;
  localparam int D2H_LEN = 20;
  localparam int SDB_LEN = 8;

  localparam logic [7:0] TYPE_D2H    = 8'h34;
  localparam logic [7:0] TYPE_SDB    = 8'hA1;
  localparam logic [7:0] ABORT_STAT  = 8'h41;
  localparam logic [7:0] ABORT_ERR   = 8'h04;
  localparam int         ERR_BIT     = 0;
  localparam int         INTR_BIT    = 6;

  typedef struct packed {
    logic             load;
    logic             emit;
    logic             fire;
    logic [IDX_W-1:0] idx;
  } ctlStrobe_t;
endpackage

// File: rtl/sata_fis_ctrl.sv
module sata_fis_ctrl
  import sata_fis_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       capSdb,
  output logic       reqReady,
  output ctlStrobe_t strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_EMIT, ST_FIRE} ctlState_t;

  ctlState_t        state;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] lastIdx;

  assign lastIdx = capSdb ? IDX_W'(SDB_LEN - 1) : IDX_W'(D2H_LEN - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (reqValid) begin
          state <= ST_EMIT;
          idx   <= '0;
        end
        ST_EMIT: if (idx == lastIdx) state <= ST_FIRE;
                 else idx <= idx + 1'b1;
        ST_FIRE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load = (state == ST_IDLE) && reqValid;
    strb.emit = (state == ST_EMIT);
    strb.fire = (state == ST_FIRE);
    strb.idx  = idx;
  end

  assign reqReady = (state == ST_IDLE);

  // R1/R2: a burst runs without gaps to its last byte
  assert_burst_gapless_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EMIT && idx != lastIdx) |=> (state == ST_EMIT));

  // R8: an accepted request leaves the idle state at once
  assert_busy_after_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> !reqReady);
endmodule

// File: rtl/sata_fis_dp.sv
module sata_fis_dp
  import sata_fis_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          D2H_BASE  = 64,
  parameter int          SDB_BASE  = 88,
  parameter logic [15:0] TFD_RESET = 16'h007F
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic              reqKind,
  input  logic              reqIntr,
  input  logic              reqAbort,
  input  logic [7:0]        reqStatus,
  input  logic [7:0]        reqError,
  input  logic [31:0]       reqFinished,
  output logic              capSdb,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              setDhrs,
  output logic              setSdbs,
  output logic              setTfes,
  output logic [15:0]       tfdValue
);
  logic        capIntr;
  logic [7:0]  capStatus;
  logic [7:0]  capError;
  logic [31:0] capFinished;
  logic        capErr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capSdb      <= 1'b0;
      capIntr     <= 1'b0;
      capStatus   <= 8'h00;
      capError    <= 8'h00;
      capFinished <= '0;
    end else if (strb.load) begin
      capSdb      <= reqKind;
      capIntr     <= reqIntr;
      capStatus   <= reqAbort ? ABORT_STAT : reqStatus;
      capError    <= reqAbort ? ABORT_ERR  : reqError;
      capFinished <= reqKind ? reqFinished : 32'h0;
    end
  end

  function automatic logic [7:0] fisByte(input logic sdb, input logic [IDX_W-1:0] i,
                                         input logic intr, input logic [7:0] st,
                                         input logic [7:0] er, input logic [31:0] fin);
    logic [7:0] b;
    b = 8'h00;
    case (i)
      IDX_W'(0): b = sdb ? TYPE_SDB : TYPE_D2H;
      IDX_W'(1): b[INTR_BIT] = intr;
      IDX_W'(2): b = st;
      IDX_W'(3): b = er;
      IDX_W'(4): b = sdb ? fin[7:0]   : 8'h00;
      IDX_W'(5): b = sdb ? fin[15:8]  : 8'h00;
      IDX_W'(6): b = sdb ? fin[23:16] : 8'h00;
      IDX_W'(7): b = sdb ? fin[31:24] : 8'h00;
      default:   b = 8'h00;
    endcase
    return b;
  endfunction

  assign wrEn   = strb.emit;
  assign wrAddr = (capSdb ? ADDR_W'(SDB_BASE) : ADDR_W'(D2H_BASE)) + ADDR_W'(strb.idx);
  assign wrData = fisByte(capSdb, strb.idx, capIntr, capStatus, capError, capFinished);

  assign capErr  = capStatus[ERR_BIT];
  assign setDhrs = strb.fire && !capSdb && capIntr;
  assign setSdbs = strb.fire &&  capSdb && !capErr && capIntr;
  assign setTfes = strb.fire && capErr;

  always_ff @(posedge clk) begin
    if (!rstN)                      tfdValue <= TFD_RESET;
    else if (strb.fire && !capSdb)  tfdValue <= {capError, capStatus};
  end

  // R3: register-frame interrupt only with its flag, on a register frame
  assert_dhrs_needs_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    setDhrs |-> (capIntr && !capSdb));

  // R5: set-device-bits and task-file error never together
  assert_sdbs_tfes_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(setSdbs && setTfes));

  // R6: an abort captures the forced status and error
  assert_abort_forced_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && reqAbort) |=> (capStatus == ABORT_STAT && capError == ABORT_ERR));

  // R7: task-file data moves only after a register-frame interrupt cycle
  assert_tfd_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.fire && !capSdb) |=> $stable(tfdValue));
endmodule

// File: rtl/sata_fis_irq_gen.sv
module sata_fis_irq_gen
  import sata_fis_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          D2H_BASE  = 64,
  parameter int          SDB_BASE  = 88,
  parameter logic [15:0] TFD_RESET = 16'h007F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqKind,
  input  logic              reqIntr,
  input  logic              reqAbort,
  input  logic [7:0]        reqStatus,
  input  logic [7:0]        reqError,
  input  logic [31:0]       reqFinished,
  output logic              reqReady,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              setDhrs,
  output logic              setSdbs,
  output logic              setTfes,
  output logic [15:0]       tfdValue
);
  ctlStrobe_t strb;
  logic       capSdb;
  logic       wrEnQ;

  sata_fis_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .capSdb(capSdb),
    .reqReady(reqReady), .strb(strb)
  );

  sata_fis_dp #(
    .ADDR_W(ADDR_W), .D2H_BASE(D2H_BASE), .SDB_BASE(SDB_BASE), .TFD_RESET(TFD_RESET)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqKind(reqKind), .reqIntr(reqIntr), .reqAbort(reqAbort),
    .reqStatus(reqStatus), .reqError(reqError), .reqFinished(reqFinished),
    .capSdb(capSdb), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .setDhrs(setDhrs), .setSdbs(setSdbs), .setTfes(setTfes), .tfdValue(tfdValue)
  );

  always_ff @(posedge clk) begin
    if (!rstN) wrEnQ <= 1'b0;
    else       wrEnQ <= wrEn;
  end

  // R3: pulses only in the cycle right after the last write
  assert_irq_after_burst_R3: assert property (@(posedge clk) disable iff (!rstN)
    (setDhrs || setSdbs || setTfes) |-> (wrEnQ && !wrEn));

  // R8: no write while idle
  assert_no_write_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !wrEn);
endmodule

// File: tb/sata_fis_irq_gen_tb.sv
module sata_fis_irq_gen_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqKind = 1'b0, reqIntr = 1'b0, reqAbort = 1'b0;
  logic [7:0]  reqStatus = 8'h00, reqError = 8'h00;
  logic [31:0] reqFinished = 32'h0;
  logic        reqReady, wrEn, setDhrs, setSdbs, setTfes;
  logic [7:0]  wrAddr, wrData;
  logic [15:0] tfdValue;

  int checks = 0;
  int errors = 0;
  logic [15:0] byteQ[$];
  logic [2:0]  irqQ[$];
  logic        prevWr = 1'b0;
  logic [15:0] tfdExp = 16'h007F;

  always #10 clk = ~clk;

  sata_fis_irq_gen dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind), .reqIntr(reqIntr),
    .reqAbort(reqAbort), .reqStatus(reqStatus), .reqError(reqError),
    .reqFinished(reqFinished), .reqReady(reqReady), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .setDhrs(setDhrs), .setSdbs(setSdbs), .setTfes(setTfes),
    .tfdValue(tfdValue)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compares writes and pulses as the design produces them
  always @(negedge clk) begin
    if (rstN) begin
      if (wrEn) begin
        if (byteQ.size() == 0) check(1'b0, "R8 unexpected write", {wrAddr, wrData}, 0);
        else begin
          logic [15:0] e;
          e = byteQ.pop_front();
          check({wrAddr, wrData} == e, "R1/R2 frame byte", {wrAddr, wrData}, e);
        end
      end
      if (prevWr && !wrEn) begin
        if (irqQ.size() == 0) check(1'b0, "R3 unexpected irq cycle", {setDhrs, setSdbs, setTfes}, 0);
        else begin
          logic [2:0] ei;
          ei = irqQ.pop_front();
          check({setDhrs, setSdbs, setTfes} == ei, "R3/R4/R5 irq pulses", {setDhrs, setSdbs, setTfes}, ei);
        end
      end else if (setDhrs || setSdbs || setTfes)
        check(1'b0, "R3 pulse outside irq cycle", {setDhrs, setSdbs, setTfes}, 0);
      prevWr <= wrEn;
    end
  end

  // driver: pushes expected bytes and pulses, then issues the request
  task automatic send(input bit kind, input bit intr, input bit abrt, input logic [7:0] st,
                      input logic [7:0] er, input logic [31:0] fin, input bit intrude);
    logic [7:0] s, e, base;
    int len;
    s = abrt ? 8'h41 : st;           // R6
    e = abrt ? 8'h04 : er;
    base = kind ? 8'd88 : 8'd64;
    len = kind ? 8 : 20;
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'h00;
      if (i == 0) b = kind ? 8'hA1 : 8'h34;
      else if (i == 1) b = {1'b0, intr, 6'b0};
      else if (i == 2) b = s;
      else if (i == 3) b = e;
      else if (kind && i < 8) b = fin[8*(i-4) +: 8];
      byteQ.push_back({base + 8'(i), b});
    end
    if (!kind) irqQ.push_back({intr, 1'b0, s[0]});
    else       irqQ.push_back({1'b0, !s[0] && intr, s[0]});
    if (!kind) tfdExp = {e, s};      // R7
    @(negedge clk);
    reqKind = kind; reqIntr = intr; reqAbort = abrt;
    reqStatus = st; reqError = er; reqFinished = fin; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R8 busy after accept", reqReady, 0);
    if (intrude) begin
      repeat (3) @(negedge clk);
      reqKind = 1'b1; reqIntr = 1'b1; reqAbort = 1'b0;
      reqStatus = 8'h41; reqError = 8'hFF; reqFinished = 32'hFFFF_FFFF; reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
    end
    while (!reqReady) @(negedge clk);
    check(tfdValue == tfdExp, "R7 task-file data", tfdValue, tfdExp);
    repeat (2) @(negedge clk);
    check(byteQ.size() == 0 && irqQ.size() == 0, "R8 stream complete", byteQ.size(), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(reqReady == 1'b1, "R9 ready after reset", reqReady, 1);
    check(wrEn == 1'b0 && !setDhrs && !setSdbs && !setTfes, "R9 quiet after reset",
          {wrEn, setDhrs, setSdbs, setTfes}, 0);
    check(tfdValue == 16'h007F, "R7 reset task-file data", tfdValue, 16'h007F);

    send(1'b0, 1'b1, 1'b0, 8'h50, 8'h00, 32'h0, 1'b0);  // R1 R3 completion
    send(1'b0, 1'b0, 1'b0, 8'h50, 8'h00, 32'h0, 1'b0);  // R3 queued ack, no irq
    send(1'b0, 1'b1, 1'b0, 8'h51, 8'h04, 32'h0, 1'b0);  // R4 with flag
    send(1'b0, 1'b0, 1'b1, 8'h50, 8'h00, 32'h0, 1'b0);  // R4 R6 abort, no flag
    send(1'b1, 1'b1, 1'b0, 8'h40, 8'h00, 32'h8000_0003, 1'b0); // R2 R5 R7
    send(1'b1, 1'b1, 1'b0, 8'h41, 8'h04, 32'h0000_0010, 1'b0); // R5 err with flag
    send(1'b1, 1'b0, 1'b0, 8'h41, 8'h04, 32'h0, 1'b0);  // R5 err without flag
    send(1'b1, 1'b0, 1'b0, 8'h40, 8'h00, 32'h1234_5678, 1'b0); // R5 quiet
    send(1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 32'h0000_0001, 1'b0); // R6 abort on sdb
    send(1'b0, 1'b1, 1'b0, 8'h50, 8'h00, 32'h0, 1'b1);  // R8 request while busy

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule